// File: doc/BRIEF.md
# Exponential Backoff Retry Pacer

This block sets the pace of retries for one requester that keeps losing a contended atomic operation, such as a compare-and-swap. It holds a spin count. A new operation sets the count to one. Each reported failure starts a pause whose length is the spin count scaled by 128 cycles. The whole length goes to an external pause timer in a single request. When the timer reports completion, the block emits a one-cycle retry permission. The count then doubles for the next failure, unless it has already passed the growth threshold. Because the threshold is tested only after the pause, the count can go one doubling past the threshold (4096 to 8192) and then stays there.

The controller has three states. `ST_IDLE` means no operation is in flight. `ST_ARMED` means an operation is in flight and not pausing. `ST_PAUSE` means a backoff wait is running. The transitions are:

- *launch*: `ST_IDLE` or any state to `ST_ARMED` on `op_start`. This reloads the count and has top priority.
- *finish*: `ST_ARMED` or `ST_PAUSE` to `ST_IDLE` on `op_success`.
- *back off*: `ST_ARMED` to `ST_PAUSE` on `op_fail`.
- *resume*: `ST_PAUSE` to `ST_ARMED` on `pause_done`.

A single-requester build (`SINGLE_CPU=1`) removes the pause completely. In that build every failure is answered with a retry permission on the next cycle.

Top module: `backoff_pacer`

## Requirements
- R1: After reset the block is idle, and `busy`, `retry_ok` and `pause_req` are all 0.
- R2: One cycle after `op_start`, the spin count is 1, so `pause_len` reads 128. `op_start` reloads the count from any state, including during a pause, and ends that pause.
- R3: An `op_fail` sampled in `ST_ARMED` makes `busy` high and `pause_req` high for exactly one cycle on the next cycle. `pause_len` equals the spin count shifted left by 7.
- R4: `retry_ok` is high for exactly the cycle in which `pause_done` is high while `busy`. `busy` is 0 on the following cycle.
- R5: After a completed pause, the count doubles if it was not greater than 4096.
- R6: After a completed pause, the count is unchanged if it was greater than 4096. Successive pauses therefore request 1,2,4,…,4096,8192,8192,… units, and the count never exceeds 8192.
- R7: An `op_fail` received while `busy` is ignored. `busy` stays high, `pause_req` does not pulse, and `pause_len` keeps its value.
- R8: `op_success` returns the block to `ST_IDLE` from `ST_ARMED` or `ST_PAUSE`, with `busy` 0 on the next cycle. An `op_fail` in `ST_IDLE` starts no pause.
- R9: A `pause_done` received while not `busy` produces no `retry_ok` and leaves the count unchanged.
- R10: With `SINGLE_CPU=1`, an `op_fail` in `ST_ARMED` produces a one-cycle `retry_ok` on the next cycle. `busy` and `pause_req` never assert, and `pause_len` stays at 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Pulse: a new atomic operation begins |
| op_fail | input | 1 | Pulse: the latest attempt failed |
| op_success | input | 1 | Pulse: the operation completed |
| pause_done | input | 1 | Pulse from the pause timer: requested wait has elapsed |
| busy | output | 1 | High while a backoff pause is in progress |
| retry_ok | output | 1 | One-cycle permission to retry |
| pause_req | output | 1 | One-cycle strobe loading `pause_len` into the pause timer |
| pause_len | output | CNT_W+SCALE_SH (21) | Requested wait in cycles: spin count shifted left by 7 |

## Verification
A long run of consecutive failures without success drives the count up the whole ladder. This separates a correct overshoot-then-freeze at 8192 from a compare done before doubling, which would stop at 4096, and from a counter that keeps growing or wraps. Failures and completions are also mixed at random with extra failures during pauses, early successes and restarts in mid-pause. These show whether the pause is protected from extra fail pulses and whether the launch and finish transitions reload or abandon the count correctly. Timer completions sent outside a pause, and a second instance built for a single requester, check that retry permission comes only from a real pause end or, in the single-requester build, straight from the failure.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PAUSE = 2'd2
    } bo_state_e;

endpackage

// File: rtl/backoff_fsm.sv
module backoff_fsm
    import backoff_pkg::*;
#(
    parameter bit SINGLE_CPU = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_fail,
    input  logic op_success,
    input  logic pause_done,
    output logic busy,
    output logic retry_ok,
    output logic pause_req,
    output logic grow
);

    localparam bit BACKOFF_ON = (SINGLE_CPU == 1'b0);

    bo_state_e state_q, state_d;
    logic      pause_req_q;
    logic      wait_end;
    logic      direct_retry;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (op_start)                      state_d = ST_ARMED;
                else if (op_success)               state_d = ST_IDLE;
                else if (op_fail && BACKOFF_ON)    state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (op_start)        state_d = ST_ARMED;
                else if (op_success) state_d = ST_IDLE;
                else if (pause_done) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pause_req_q <= 1'b0;
        else        pause_req_q <= (state_q != ST_PAUSE) && (state_d == ST_PAUSE);
    end

    generate
        if (SINGLE_CPU) begin : g_direct
            logic dr_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dr_q <= 1'b0;
                else        dr_q <= (state_q == ST_ARMED) && op_fail &&
                                    !op_start && !op_success;
            end
            assign direct_retry = dr_q;
        end else begin : g_paced
            assign direct_retry = 1'b0;
        end
    endgenerate

    // combinational outputs
    always_comb begin
        wait_end  = (state_q == ST_PAUSE) && pause_done && !op_start && !op_success;
        busy      = (state_q == ST_PAUSE);
        retry_ok  = wait_end || direct_retry;
        pause_req = pause_req_q;
        grow      = wait_end;
    end

    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |=> !pause_req);
    p_req_with_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> busy);
    p_retry_ends_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_ok && BACKOFF_ON) |=> !busy);
    p_fail_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_fail && !pause_done && !op_start && !op_success) |=> (busy && !pause_req));
    p_success_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_success && !op_start) |=> !busy);
    p_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && BACKOFF_ON) |-> !retry_ok);
    p_uni_nobusy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !BACKOFF_ON |-> (!busy && !pause_req));

endmodule

// File: rtl/backoff_count.sv
module backoff_count #(
    parameter int LIMIT = 4096,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             grow,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] TOP    = CNT_W'(2 * LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic             may_double;

    always_comb may_double = (cnt_q <= THRESH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= ONE;
        else if (load)               cnt_q <= ONE;
        else if (grow && may_double) cnt_q <= {cnt_q[CNT_W-2:0], 1'b0};
    end

    assign cnt = cnt_q;

    p_load_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == ONE));
    p_double_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grow && !load && cnt <= THRESH) |=> (cnt == ($past(cnt) + $past(cnt))));
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grow && !load && cnt > THRESH) |=> $stable(cnt));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= TOP) && ($countones(cnt) == 1));

endmodule

// File: rtl/backoff_pacer.sv
module backoff_pacer #(
    parameter bit SINGLE_CPU = 1'b0,
    parameter int LIMIT      = 4096,
    parameter int SCALE_SH   = 7,
    parameter int CNT_W      = $clog2(LIMIT) + 2,
    parameter int LEN_W      = CNT_W + SCALE_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             op_fail,
    input  logic             op_success,
    input  logic             pause_done,
    output logic             busy,
    output logic             retry_ok,
    output logic             pause_req,
    output logic [LEN_W-1:0] pause_len
);

    logic             grow;
    logic [CNT_W-1:0] cnt;

    backoff_fsm #(.SINGLE_CPU(SINGLE_CPU)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_fail    (op_fail),
        .op_success (op_success),
        .pause_done (pause_done),
        .busy       (busy),
        .retry_ok   (retry_ok),
        .pause_req  (pause_req),
        .grow       (grow)
    );

    backoff_count #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op_start),
        .grow  (grow),
        .cnt   (cnt)
    );

    // whole wait issued at once: count scaled by 2**SCALE_SH
    assign pause_len = {cnt, {SCALE_SH{1'b0}}};

    p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pause_done && !op_start) |=> $stable(pause_len));
    p_len_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !op_start) |=> $stable(pause_len));

endmodule

// File: tb/backoff_pacer_tb.sv
module backoff_pacer_tb;

    localparam int LIM = 4096;
    localparam int LW  = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 0, op_fail = 0, op_success = 0, pause_done = 0;
    logic busy, retry_ok, pause_req;
    logic [LW-1:0] pause_len;
    logic u_start = 0, u_fail = 0;
    logic u_busy, u_retry, u_req;
    logic [LW-1:0] u_len;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 1;

    always #10 clk = ~clk;

    backoff_pacer u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_fail(op_fail),
        .op_success(op_success), .pause_done(pause_done), .busy(busy),
        .retry_ok(retry_ok), .pause_req(pause_req), .pause_len(pause_len));

    backoff_pacer #(.SINGLE_CPU(1'b1)) u_dut_up (
        .clk(clk), .rst_n(rst_n), .op_start(u_start), .op_fail(u_fail),
        .op_success(1'b0), .pause_done(1'b0), .busy(u_busy),
        .retry_ok(u_retry), .pause_req(u_req), .pause_len(u_len));

    function automatic int grown(input int c);
        return (c <= LIM) ? c * 2 : c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic start_op();
        @(negedge clk) op_start = 1;
        @(negedge clk) op_start = 0;
        exp_cnt = 1;
        chk(int'(pause_len) == 128, "R2 start reload", int'(pause_len), 128);
        chk(!busy, "R2 not busy after start", busy, 0);
    endtask

    // one failure, pause of dly cycles, optional stray fail, then completion
    task automatic fail_cycle(input int dly, input bit extra, input bit abort);
        @(negedge clk) op_fail = 1;
        @(negedge clk) op_fail = 0;
        chk(busy && pause_req, "R3 pause begins", {busy, pause_req}, 3);
        chk(int'(pause_len) == (exp_cnt << 7), "R3 pause length",
            int'(pause_len), exp_cnt << 7);
        for (int k = 0; k < dly; k++) begin
            if (extra && k == 0) op_fail = 1;
            @(negedge clk) op_fail = 0;
            chk(busy && !pause_req, "R7 pause undisturbed", {busy, pause_req}, 2);
            chk(int'(pause_len) == (exp_cnt << 7), "R7 length held",
                int'(pause_len), exp_cnt << 7);
        end
        if (abort) begin
            op_start = 1;
            @(negedge clk) op_start = 0;
            exp_cnt = 1;
            chk(!busy && int'(pause_len) == 128, "R2 restart mid-pause",
                int'(pause_len), 128);
            return;
        end
        pause_done = 1;
        #1;
        chk(retry_ok, "R4 retry with done", retry_ok, 1);
        @(negedge clk) pause_done = 0;
        exp_cnt = grown(exp_cnt);
        chk(!busy && !retry_ok, "R4 pulse ends", {busy, retry_ok}, 0);
        chk(int'(pause_len) == (exp_cnt << 7), "R5/R6 count update",
            int'(pause_len), exp_cnt << 7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #25;
        chk(!busy && !retry_ok && !pause_req, "R1 reset outputs",
            {busy, retry_ok, pause_req}, 0);
        rst_n = 1;
        @(negedge clk);
        // R8: fail while idle starts nothing
        op_fail = 1;
        @(negedge clk) op_fail = 0;
        @(negedge clk);
        chk(!busy && !pause_req, "R8 idle fail ignored", busy, 0);

        start_op();
        // R9: stray done while armed
        pause_done = 1;
        #1;
        chk(!retry_ok, "R9 stray done no retry", retry_ok, 0);
        @(negedge clk) pause_done = 0;
        chk(int'(pause_len) == 128, "R9 count unchanged", int'(pause_len), 128);

        // R5/R6 ladder up to and beyond freeze
        for (int i = 0; i < 16; i++) fail_cycle(1, 1'b0, 1'b0);
        chk(exp_cnt == 8192 && int'(pause_len) == (8192 << 7), "R6 frozen at 8192",
            int'(pause_len), 8192 << 7);

        // R8: success during a pause
        start_op();
        @(negedge clk) op_fail = 1;
        @(negedge clk) op_fail = 0;
        op_success = 1;
        @(negedge clk) op_success = 0;
        chk(!busy, "R8 success ends pause", busy, 0);
        @(negedge clk) op_fail = 1;
        @(negedge clk) op_fail = 0;
        chk(!busy, "R8 idle after success", busy, 0);

        // R10: single-requester instance
        @(negedge clk) u_start = 1;
        @(negedge clk) u_start = 0;
        for (int i = 0; i < 4; i++) begin
            u_fail = 1;
            @(negedge clk) u_fail = 0;
            chk(u_retry && !u_busy && !u_req, "R10 direct retry",
                {u_retry, u_busy, u_req}, 4);
            @(negedge clk);
            chk(!u_retry && int'(u_len) == 128, "R10 pulse and length",
                int'(u_len), 128);
        end

        // constrained random mix
        start_op();
        for (int it = 0; it < 300; it++) begin
            int r;
            r = $urandom_range(0, 11);
            if (r == 0) begin
                @(negedge clk) op_success = 1;
                @(negedge clk) op_success = 0;
                chk(!busy, "R8 success idle", busy, 0);
                start_op();
            end else if (r == 1) begin
                start_op();
            end else begin
                fail_cycle($urandom_range(0, 5), ($urandom_range(0, 2) == 0),
                           ($urandom_range(0, 9) == 0));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule